// File: doc/BRIEF.md
# Resistive Weight Array Preparation Sequencer

This block steers the one-time preparation of a weight array in which every binary weight is stored as a pair of resistive cells held in opposite states. After a start request it first forms every cell of the array, one cell after another. It then waits for weight rows from a host and writes them one row at a time, driving each pair to complementary resistance states according to the weight bit. Each cell operation selects a set of programming rail levels, waits one settling cycle, asserts the power switch and the word-line and cell enables for a fixed number of clock cycles, and keeps the rail selects for one more cycle after the pulse ends.

The rail levels are given only as select codes for an external power switch. The pulse lengths come from the clock frequency and the required durations: ten microseconds for forming and six microseconds for programming. Once the first pass is done, a further start request rewrites the weights without forming the cells again.

Top module: `rram_prep_seq`

## Requirements
- R1: After reset, all three rail selects read 0 (off), and `pwr_en`, `wl_en`, `cell_en`, `row_ready`, `busy` and `done` are all low.
- R2: After `start` from idle, every cell gets exactly one forming pulse. The order is row by row from 0, then columns in ascending order, with side A before side B in each column. During each pulse exactly one `wl_en` bit (bit r for row r) and exactly one `cell_en` bit (bit 2*c+s for column c, with side A = 0 and side B = 1) is high. Outside a pulse both are zero.
- R3: A forming pulse selects code 3 (4.5 V) on `bl_rail`, code 2 (2.7 V) on `wl_rail` and code 1 (1.2 V) on `core_rail`. It lasts CLK_MHZ*FORM_NS/1000 cycles.
- R4: The rail selects of an operation are present for one cycle before `pwr_en` rises, stay unchanged while it is high, and are kept for the cycle after it falls.
- R5: After forming, `row_ready` is high. A row is taken in the cycle where `row_valid` and `row_ready` are both high, and `row_ready` drops once the row is taken. Rows are programmed in order 0 to ROWS-1. Within a row, columns go in ascending order, with side A and then side B.
- R6: Bit c of `row_data` is the weight of column c. For weight 1, side A is set to low resistance (`bl_rail` 2, `wl_rail` 2) and side B to high resistance (`bl_rail` 2, `wl_rail` 3). Weight 0 swaps the two sides. `core_rail` is 1 in both cases.
- R7: A programming pulse lasts CLK_MHZ*PROG_NS/1000 cycles.
- R8: While `row_ready` is high and `row_valid` is low, no pulse is issued and `row_ready` stays high.
- R9: After the pair in the last column of the last row, `done` goes high and `busy` goes low. A new `start` then programs a full set of rows with no forming pulse.
- R10: `busy` is high from the cycle after an accepted `start` until `done`. `row_ready` is only ever high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin forming (from idle) or reprogramming (from done) |
| row_valid | input | 1 | Host presents a weight row |
| row_data | input | COLS | Weight bits, bit c for column c |
| row_ready | output | 1 | Sequencer can take a row |
| busy | output | 1 | Preparation in progress |
| done | output | 1 | All rows written |
| bl_rail | output | 2 | Cell-side rail select: 0 off, 1 1.2 V, 2 2.7 V, 3 4.5 V |
| wl_rail | output | 2 | Row-side rail select, same coding |
| core_rail | output | 2 | Logic supply select, same coding |
| pwr_en | output | 1 | Power switch pulse enable |
| wl_en | output | ROWS | Per-row pulse enable |
| cell_en | output | 2*COLS | Per-cell pulse enable, bit 2*c+s |

## Verification
The bench builds the block with ROWS=3, COLS=4, CLK_MHZ=1, FORM_NS=4000 and PROG_NS=3000. This gives 4-cycle forming pulses and 3-cycle programming pulses, so a pulse of the wrong kind or length shows up as a length mismatch. The small array lets a run cover the whole 24-cell forming pass, every column and row wrap, both weight polarities in every row, a host stall while `row_ready` is high, and a second programming pass that must contain no forming pulse.

// File: rtl/rps_pkg.sv
package rps_pkg;

    typedef enum logic [1:0] {
        RAIL_OFF = 2'd0,
        RAIL_1V2 = 2'd1,
        RAIL_2V7 = 2'd2,
        RAIL_4V5 = 2'd3
    } rail_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_FORM,
        SQ_WAIT_ROW,
        SQ_PROG_A,
        SQ_PROG_B,
        SQ_NEXT,
        SQ_DONE
    } seq_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_PULSE,
        PH_HOLD
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_FORM,
        OP_SET_LOW,
        OP_SET_HIGH
    } op_e;

    typedef struct packed {
        rail_e bl;
        rail_e wl;
        rail_e core;
    } rails_t;

    // Rail levels needed by each kind of cell operation.
    function automatic rails_t rails_for(op_e op);
        rails_t r;
        r = '{bl: RAIL_OFF, wl: RAIL_OFF, core: RAIL_OFF};
        case (op)
            OP_FORM:     r = '{bl: RAIL_4V5, wl: RAIL_2V7, core: RAIL_1V2};
            OP_SET_LOW:  r = '{bl: RAIL_2V7, wl: RAIL_2V7, core: RAIL_1V2};
            OP_SET_HIGH: r = '{bl: RAIL_2V7, wl: RAIL_4V5, core: RAIL_1V2};
            default:     ;
        endcase
        return r;
    endfunction

    // Side A follows the weight (1 -> low resistance); side B takes the opposite state.
    function automatic op_e prog_op(logic weight, logic side_b);
        return (weight ^ side_b) ? OP_SET_LOW : OP_SET_HIGH;
    endfunction

endpackage

// File: rtl/rps_pulse_timer.sv
module rps_pulse_timer
    import rps_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          kick,
    input  logic [TW-1:0] len,
    output phase_e        phase,
    output logic          last
);

    phase_e        ph_q;
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE, PH_HOLD: begin
                    if (kick) begin
                        ph_q  <= PH_SETTLE;
                        cnt_q <= len;
                    end else begin
                        ph_q <= PH_IDLE;
                    end
                end
                PH_SETTLE: ph_q <= PH_PULSE;
                PH_PULSE: begin
                    if (cnt_q == TW'(1)) ph_q <= PH_HOLD;
                    cnt_q <= cnt_q - TW'(1);
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign phase = ph_q;
    assign last  = (ph_q == PH_HOLD);

endmodule

// File: rtl/rps_cell_walker.sv
module rps_cell_walker #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int RW   = 2,
    parameter int CW   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv_cell,
    input  logic          adv_col,
    input  logic          adv_row,
    output logic [RW-1:0] row,
    output logic [CW-1:0] col,
    output logic          side,
    output logic          last_col,
    output logic          last_row,
    output logic          last_cell
);

    assign last_col  = (col == CW'(COLS - 1));
    assign last_row  = (row == RW'(ROWS - 1));
    assign last_cell = last_col && last_row && side;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            row  <= '0;
            col  <= '0;
            side <= 1'b0;
        end else if (adv_cell) begin
            if (side) begin
                side <= 1'b0;
                if (last_col) begin
                    col <= '0;
                    row <= row + RW'(1);
                end else begin
                    col <= col + CW'(1);
                end
            end else begin
                side <= 1'b1;
            end
        end else if (adv_col) begin
            col <= col + CW'(1);
        end else if (adv_row) begin
            row <= row + RW'(1);
            col <= '0;
        end
    end

endmodule

// File: rtl/rps_line_decode.sv
module rps_line_decode #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int RW   = 2,
    parameter int CW   = 2
) (
    input  logic              pulse,
    input  logic [RW-1:0]     row,
    input  logic [CW-1:0]     col,
    input  logic              side,
    output logic [ROWS-1:0]   wl_en,
    output logic [2*COLS-1:0] cell_en
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign wl_en[r] = pulse && (row == RW'(r));
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign cell_en[2*c]     = pulse && (col == CW'(c)) && !side;
        assign cell_en[2*c + 1] = pulse && (col == CW'(c)) && side;
    end

endmodule

// File: rtl/rram_prep_seq.sv
module rram_prep_seq
    import rps_pkg::*;
#(
    parameter int ROWS    = 64,
    parameter int COLS    = 128,
    parameter int CLK_MHZ = 50,
    parameter int FORM_NS = 10000,
    parameter int PROG_NS = 6000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              row_valid,
    input  logic [COLS-1:0]   row_data,
    output logic              row_ready,
    output logic              busy,
    output logic              done,
    output logic [1:0]        bl_rail,
    output logic [1:0]        wl_rail,
    output logic [1:0]        core_rail,
    output logic              pwr_en,
    output logic [ROWS-1:0]   wl_en,
    output logic [2*COLS-1:0] cell_en
);

    localparam int RW       = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CW       = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int FORM_RAW = CLK_MHZ * FORM_NS / 1000;
    localparam int PROG_RAW = CLK_MHZ * PROG_NS / 1000;
    localparam int FORM_CYC = (FORM_RAW < 1) ? 1 : FORM_RAW;
    localparam int PROG_CYC = (PROG_RAW < 1) ? 1 : PROG_RAW;
    localparam int MAX_CYC  = (FORM_CYC > PROG_CYC) ? FORM_CYC : PROG_CYC;
    localparam int TW       = $clog2(MAX_CYC + 1);

    seq_e            state_q, state_d;
    logic            kick;
    logic            w_clr, w_adv_cell, w_adv_col, w_adv_row;
    logic            load_row;
    logic [COLS-1:0] row_q;
    logic [TW-1:0]   pulse_len;
    phase_e          phase;
    logic            t_last;
    logic [RW-1:0]   w_row;
    logic [CW-1:0]   w_col;
    logic            w_side;
    logic            w_last_col, w_last_row, w_last_cell;
    logic            side_cur;
    op_e             op_cur;
    rails_t          rails;

    // Sequencing: forming pass, then row-by-row complementary programming.
    always_comb begin
        state_d    = state_q;
        kick       = 1'b0;
        w_clr      = 1'b0;
        w_adv_cell = 1'b0;
        w_adv_col  = 1'b0;
        w_adv_row  = 1'b0;
        load_row   = 1'b0;
        case (state_q)
            SQ_IDLE: begin
                if (start) begin
                    state_d = SQ_FORM;
                    kick    = 1'b1;
                    w_clr   = 1'b1;
                end
            end
            SQ_FORM: begin
                if (t_last) begin
                    if (w_last_cell) begin
                        state_d = SQ_WAIT_ROW;
                        w_clr   = 1'b1;
                    end else begin
                        w_adv_cell = 1'b1;
                        kick       = 1'b1;
                    end
                end
            end
            SQ_WAIT_ROW: begin
                if (row_valid) begin
                    load_row = 1'b1;
                    state_d  = SQ_PROG_A;
                    kick     = 1'b1;
                end
            end
            SQ_PROG_A: begin
                if (t_last) begin
                    state_d = SQ_PROG_B;
                    kick    = 1'b1;
                end
            end
            SQ_PROG_B: begin
                if (t_last) state_d = SQ_NEXT;
            end
            SQ_NEXT: begin
                if (w_last_col) begin
                    if (w_last_row) begin
                        state_d = SQ_DONE;
                        w_clr   = 1'b1;
                    end else begin
                        w_adv_row = 1'b1;
                        state_d   = SQ_WAIT_ROW;
                    end
                end else begin
                    w_adv_col = 1'b1;
                    state_d   = SQ_PROG_A;
                    kick      = 1'b1;
                end
            end
            SQ_DONE: begin
                if (start) state_d = SQ_WAIT_ROW;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load_row) row_q <= row_data;
        end
    end

    assign pulse_len = (state_q == SQ_IDLE || state_q == SQ_FORM) ? TW'(FORM_CYC) : TW'(PROG_CYC);

    rps_pulse_timer #(
        .TW(TW)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .kick  (kick),
        .len   (pulse_len),
        .phase (phase),
        .last  (t_last)
    );

    rps_cell_walker #(
        .ROWS(ROWS),
        .COLS(COLS),
        .RW  (RW),
        .CW  (CW)
    ) u_walker (
        .clk       (clk),
        .rst       (rst),
        .clr       (w_clr),
        .adv_cell  (w_adv_cell),
        .adv_col   (w_adv_col),
        .adv_row   (w_adv_row),
        .row       (w_row),
        .col       (w_col),
        .side      (w_side),
        .last_col  (w_last_col),
        .last_row  (w_last_row),
        .last_cell (w_last_cell)
    );

    // Operation and rail selection, gated by the timer so that rails are off between operations.
    assign side_cur = (state_q == SQ_FORM) ? w_side : (state_q == SQ_PROG_B);

    always_comb begin
        if (phase == PH_IDLE)        op_cur = OP_NONE;
        else if (state_q == SQ_FORM) op_cur = OP_FORM;
        else                         op_cur = prog_op(row_q[w_col], side_cur);
    end

    assign rails     = rails_for(op_cur);
    assign bl_rail   = rails.bl;
    assign wl_rail   = rails.wl;
    assign core_rail = rails.core;
    assign pwr_en    = (phase == PH_PULSE);

    rps_line_decode #(
        .ROWS(ROWS),
        .COLS(COLS),
        .RW  (RW),
        .CW  (CW)
    ) u_decode (
        .pulse   (pwr_en),
        .row     (w_row),
        .col     (w_col),
        .side    (side_cur),
        .wl_en   (wl_en),
        .cell_en (cell_en)
    );

    assign row_ready = (state_q == SQ_WAIT_ROW);
    assign done      = (state_q == SQ_DONE);
    assign busy      = (state_q != SQ_IDLE) && (state_q != SQ_DONE);

endmodule

// File: rtl/rps_seq_chk.sv
module rps_seq_chk #(
    parameter int ROWS     = 4,
    parameter int COLS     = 4,
    parameter int FORM_CYC = 1,
    parameter int PROG_CYC = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              row_ready,
    input logic              pwr_en,
    input logic [1:0]        bl_rail,
    input logic [1:0]        wl_rail,
    input logic [1:0]        core_rail,
    input logic [ROWS-1:0]   wl_en,
    input logic [2*COLS-1:0] cell_en
);

    int run_len;

    always_ff @(posedge clk) begin
        if (rst)         run_len <= 0;
        else if (pwr_en) run_len <= run_len + 1;
        else             run_len <= 0;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bl_rail == 2'd0 && wl_rail == 2'd0 && core_rail == 2'd0 && !pwr_en));

    // R2
    one_line_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_en |-> ($countones(wl_en) == 1 && $countones(cell_en) == 1));

    // R2
    quiet_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |-> (wl_en == '0 && cell_en == '0));

    // R3
    form_rails_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_en && bl_rail == 2'd3) |-> (wl_rail == 2'd2 && core_rail == 2'd1));

    // R6
    prog_rails_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_en && bl_rail != 2'd3) |-> (bl_rail == 2'd2 && wl_rail >= 2'd2 && core_rail == 2'd1));

    // R4
    rails_settle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_en) |-> ($stable(bl_rail) && $stable(wl_rail) && $stable(core_rail)));

    // R4
    rails_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_en && $past(pwr_en)) |-> ($stable(bl_rail) && $stable(wl_rail) && $stable(core_rail)));

    // R4
    rails_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_en) |-> ($stable(bl_rail) && $stable(wl_rail) && $stable(core_rail)));

    // R7 (programming) and R3 (forming) pulse length
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_en) |-> (run_len == ((bl_rail == 2'd3) ? FORM_CYC : PROG_CYC)));

    // R10
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        row_ready |-> busy);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !pwr_en));

endmodule

bind rram_prep_seq rps_seq_chk #(
    .ROWS    (ROWS),
    .COLS    (COLS),
    .FORM_CYC(FORM_CYC),
    .PROG_CYC(PROG_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .row_ready (row_ready),
    .pwr_en    (pwr_en),
    .bl_rail   (bl_rail),
    .wl_rail   (wl_rail),
    .core_rail (core_rail),
    .wl_en     (wl_en),
    .cell_en   (cell_en)
);

// File: tb/rram_prep_seq_test.sv
`timescale 1ns/1ps
module rram_prep_seq_test;

    localparam int ROWS     = 3;
    localparam int COLS     = 4;
    localparam int FORM_LEN = 4;  // 1 MHz x 4000 ns
    localparam int PROG_LEN = 3;  // 1 MHz x 3000 ns

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              row_valid = 1'b0;
    logic [COLS-1:0]   row_data = '0;
    logic              row_ready, busy, done;
    logic [1:0]        bl_rail, wl_rail, core_rail;
    logic              pwr_en;
    logic [ROWS-1:0]   wl_en;
    logic [2*COLS-1:0] cell_en;

    always #2 clk = ~clk;

    rram_prep_seq #(
        .ROWS   (ROWS),
        .COLS   (COLS),
        .CLK_MHZ(1),
        .FORM_NS(4000),
        .PROG_NS(3000)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .row_valid (row_valid),
        .row_data  (row_data),
        .row_ready (row_ready),
        .busy      (busy),
        .done      (done),
        .bl_rail   (bl_rail),
        .wl_rail   (wl_rail),
        .core_rail (core_rail),
        .pwr_en    (pwr_en),
        .wl_en     (wl_en),
        .cell_en   (cell_en)
    );

    typedef struct {
        int       row;
        int       col;
        int       side;
        logic [1:0] bl;
        logic [1:0] wl;
        logic [1:0] core;
        int       len;
        bit       is_form;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;

    task automatic check_eq(string tag, string what, longint act, longint expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic push_form_all();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                for (int s = 0; s < 2; s++) begin
                    exp_t e;
                    e = '{row: r, col: c, side: s, bl: 2'd3, wl: 2'd2, core: 2'd1,
                          len: FORM_LEN, is_form: 1'b1};
                    exp_q.push_back(e);
                end
    endtask

    task automatic push_row(int r, logic [COLS-1:0] bits);
        for (int c = 0; c < COLS; c++)
            for (int s = 0; s < 2; s++) begin
                exp_t e;
                bit   low;
                low = (s == 0) ? bits[c] : !bits[c];
                e = '{row: r, col: c, side: s, bl: 2'd2, wl: (low ? 2'd2 : 2'd3), core: 2'd1,
                      len: PROG_LEN, is_form: 1'b0};
                exp_q.push_back(e);
            end
    endtask

    // Monitor: measures each pulse at the ports and compares it with the queue head.
    logic              prev_pwr = 1'b0;
    logic [1:0]        prev_bl = '0, prev_wl = '0, prev_core = '0;
    logic [1:0]        cap_bl, cap_wl, cap_core;
    logic [ROWS-1:0]   cap_wl_en;
    logic [2*COLS-1:0] cap_cell;
    int                run_len = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_pwr = 1'b0;
            run_len  = 0;
        end else begin
            if (pwr_en && !prev_pwr) begin
                check_eq("R4", "rails before pulse", {prev_bl, prev_wl, prev_core},
                         {bl_rail, wl_rail, core_rail});
                cap_bl    = bl_rail;
                cap_wl    = wl_rail;
                cap_core  = core_rail;
                cap_wl_en = wl_en;
                cap_cell  = cell_en;
                run_len   = 1;
            end else if (pwr_en) begin
                run_len++;
            end else if (prev_pwr) begin
                check_eq("R4", "rails after pulse", {bl_rail, wl_rail, core_rail},
                         {cap_bl, cap_wl, cap_core});
                if (exp_q.size() == 0) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL R9 unexpected pulse: actual bl=%0d wl=%0d expected none",
                             cap_bl, cap_wl);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check_eq(e.is_form ? "R2" : "R5", "row enable", cap_wl_en, 1 << e.row);
                    check_eq(e.is_form ? "R2" : "R5", "cell enable", cap_cell,
                             1 << (2 * e.col + e.side));
                    check_eq(e.is_form ? "R3" : "R6", "cell rail", cap_bl, e.bl);
                    check_eq(e.is_form ? "R3" : "R6", "row rail", cap_wl, e.wl);
                    check_eq(e.is_form ? "R3" : "R6", "core rail", cap_core, e.core);
                    check_eq(e.is_form ? "R3" : "R7", "pulse length", run_len, e.len);
                end
            end
            prev_pwr  = pwr_en;
            prev_bl   = bl_rail;
            prev_wl   = wl_rail;
            prev_core = core_rail;
        end
    end

    task automatic wait_ready();
        int guard = 0;
        while (!row_ready && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic send_row(logic [COLS-1:0] bits);
        wait_ready();
        row_valid = 1'b1;
        row_data  = bits;
        @(negedge clk);
        row_valid = 1'b0;
        row_data  = '0;
        check_eq("R5", "ready drops after row taken", row_ready, 0);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [COLS-1:0] pass1 [ROWS];
        logic [COLS-1:0] pass2 [ROWS];
        pass1[0] = 4'b1100; pass1[1] = 4'b0011; pass1[2] = 4'b1010;
        pass2[0] = 4'b0101; pass2[1] = 4'b1111; pass2[2] = 4'b0000;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_eq("R1", "cell rail", bl_rail, 0);
        check_eq("R1", "row rail", wl_rail, 0);
        check_eq("R1", "core rail", core_rail, 0);
        check_eq("R1", "pulse enables", {pwr_en, wl_en, cell_en}, 0);
        check_eq("R1", "handshake", {row_ready, busy, done}, 0);

        // R2/R3 forming pass
        push_form_all();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R10", "busy after start", busy, 1);
        repeat (10) @(negedge clk);
        // data offered while not ready must not be taken (R8 context)
        check_eq("R10", "ready low while forming", row_ready, 0);

        wait_ready();
        check_eq("R5", "forming complete before ready", exp_q.size(), 0);
        // R8: host stalls, nothing happens
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_eq("R8", "no pulse while stalled", pwr_en, 0);
            check_eq("R8", "ready held while stalled", row_ready, 1);
        end

        for (int r = 0; r < ROWS; r++) begin
            push_row(r, pass1[r]);
            send_row(pass1[r]);
        end
        wait_done();
        @(negedge clk);
        check_eq("R9", "done after last row", done, 1);
        check_eq("R9", "busy after last row", busy, 0);
        check_eq("R9", "all pulses seen", exp_q.size(), 0);

        // R9 reprogram without forming
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R10", "busy on reprogram", busy, 1);
        check_eq("R9", "ready on reprogram", row_ready, 1);
        for (int r = 0; r < ROWS; r++) begin
            push_row(r, pass2[r]);
            send_row(pass2[r]);
        end
        wait_done();
        @(negedge clk);
        check_eq("R9", "done after reprogram", done, 1);
        check_eq("R9", "reprogram pulses seen", exp_q.size(), 0);
        repeat (3) @(negedge clk);
        report();
    end

endmodule